// File: doc/BRIEF.md
# Segmented Gamma Table Loader

This block receives register writes that load a three-part gamma correction table for one pixel pipe, and holds the table for the curve evaluator. The darkest part of the curve, the superfine part, is nine entries deep and is loaded through an index/data register pair of its own. The fine and coarse parts share a second index/data pair. One auto-incrementing pointer walks through 256 fine entries and then through 256 coarse entries, so software writes all 512 entries as a single stream after one index write.

Each table entry holds a 16-bit red, a 16-bit green and a 16-bit blue value and is delivered as two consecutive 32-bit data writes. The first word carries the upper ten bits of each channel. The second word carries the lower six bits. The entry is stored only once the second word has arrived. Three 16-bit endpoint registers hold the red, green and blue output values for a full-scale input. A combinational read port lets the evaluator fetch any stored entry. A sticky flag is raised for each stream when a data write arrives after that stream's segment is full.

Top module: `gamma_lut_loader`

## Requirements
- R1: After reset the three endpoint outputs are zero, both overflow flags are low, and every table location reads as zero.
- R2: A data write pair forms the entry. In the first word, red[15:6] is at bits 29:20, green[15:6] at bits 19:10 and blue[15:6] at bits 9:0. In the second word, red[5:0] is at bits 29:24, green[5:0] at bits 19:14 and blue[5:0] at bits 9:4. The first word alone leaves the table unchanged. The entry is stored when the second word arrives.
- R3: Write address 0 is the superfine index register and address 1 is the superfine data register. Writing the index with bit 15 set and bits 3:0 equal to zero, then sending nine pairs, fills superfine entries 0 to 8 in order.
- R4: Write address 2 is the shared index register and address 3 is the shared data register. After the shared index is written with bit 15 set and bits 9:0 equal to zero, pairs 0 to 255 land in fine slots 1 to 256. Fine slot 0 is never written.
- R5: Pairs 256 to 511 of the same stream land in coarse slots 0 to 255 with no further index write, and the shared overflow flag stays low.
- R6: A data write after superfine entry 8, or after coarse slot 255, is ignored and sets that stream's overflow flag. The flag stays set until reset, even across index writes.
- R7: Any index write discards a pending first word, so the next two data writes form a complete new entry.
- R8: The index register's low bits give the starting entry position. When bit 15 is clear, the pointer does not advance, and successive pairs overwrite the same entry.
- R9: Write addresses 4, 5 and 6 load wr_data[15:0] into the red, green and blue endpoint registers, and the upper bits are dropped. Address 7 changes nothing.
- R10: Read select 0 selects superfine, 1 selects fine, 2 selects coarse and 3 selects nothing. rd_entry is {red, green, blue}. Select 3, or an index past the end of the selected segment, reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Register write data |
| rd_seg | input | 2 | Read segment select |
| rd_idx | input | 9 | Read entry index |
| rd_entry | output | 48 | Selected entry {red, green, blue} |
| max_r | output | 16 | Red endpoint value |
| max_g | output | 16 | Green endpoint value |
| max_b | output | 16 | Blue endpoint value |
| ovf_sf | output | 1 | Superfine stream overflow, sticky |
| ovf_ms | output | 1 | Shared stream overflow, sticky |

## Verification
A stale half-entry or a word pointer that is off by one does not stay hidden. The next stored entry shows swapped or shifted channel bits, or lands one slot away from where it should, and the read port shows this the cycle after the second word. A pointer that slips at the fine-to-coarse boundary shifts every later coarse entry, so a check of coarse slot 0 and of the last slot exposes it within one stream. Overflow tracking that is wrong shows as an overwritten last entry or an overflow flag that does not match, one cycle after the extra write.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

    localparam int CH_W      = 16;
    localparam int HI_W      = 10;
    localparam int LO_W      = 6;
    localparam int AUTO_BIT  = 15;

    localparam logic [2:0] REG_SF_INDEX = 3'd0;
    localparam logic [2:0] REG_SF_DATA  = 3'd1;
    localparam logic [2:0] REG_MS_INDEX = 3'd2;
    localparam logic [2:0] REG_MS_DATA  = 3'd3;
    localparam logic [2:0] REG_MAX_R    = 3'd4;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } lut_entry_t;

    typedef enum logic [1:0] {
        SEG_SUPERFINE = 2'd0,
        SEG_FINE      = 2'd1,
        SEG_COARSE    = 2'd2,
        SEG_NONE      = 2'd3
    } seg_sel_e;

endpackage

// File: rtl/gamma_stream_ctl.sv
module gamma_stream_ctl
    import gamma_lut_pkg::*;
#(
    parameter int DEPTH = 9,
    parameter int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic             data_wr,
    input  logic [31:0]      wdata,
    output logic             commit,
    output logic [PTR_W-1:0] ptr,
    output lut_entry_t       entry,
    output logic             ovf
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             auto_inc;
        logic             half;
        logic [HI_W-1:0]  hr;
        logic [HI_W-1:0]  hg;
        logic [HI_W-1:0]  hb;
        logic             ovf;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       in_range;
    logic       unused_bits;

    assign unused_bits = ^wdata[31:30];
    assign in_range    = st_q.ptr < PTR_W'(DEPTH);

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;
        if (idx_wr) begin
            st_d.ptr      = wdata[PTR_W-1:0];
            st_d.auto_inc = wdata[AUTO_BIT];
            st_d.half     = 1'b0;
        end else if (data_wr) begin
            if (!in_range) begin
                st_d.ovf = 1'b1;
            end else if (!st_q.half) begin
                st_d.hr   = wdata[29:20];
                st_d.hg   = wdata[19:10];
                st_d.hb   = wdata[9:0];
                st_d.half = 1'b1;
            end else begin
                commit    = 1'b1;
                st_d.half = 1'b0;
                if (st_q.auto_inc) begin
                    st_d.ptr = st_q.ptr + PTR_W'(1);
                end
            end
        end
    end

    assign entry.r = {st_q.hr, wdata[29:24]};
    assign entry.g = {st_q.hg, wdata[19:14]};
    assign entry.b = {st_q.hb, wdata[9:4]};
    assign ptr     = st_q.ptr;
    assign ovf     = st_q.ovf;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gamma_seg_mem.sv
module gamma_seg_mem
    import gamma_lut_pkg::*;
#(
    parameter int DEPTH = 9,
    parameter int AW    = $clog2(DEPTH),
    parameter int RAW   = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  lut_entry_t     wdata,
    input  logic [RAW-1:0] raddr,
    output lut_entry_t     rdata
);

    lut_entry_t mem_d [DEPTH];
    lut_entry_t mem_q [DEPTH];
    logic       w_ok;
    logic       r_ok;

    assign w_ok = {1'b0, waddr} < (AW + 1)'(DEPTH);
    assign r_ok = {1'b0, raddr} < (RAW + 1)'(DEPTH);

    always_comb begin
        mem_d = mem_q;
        if (we && w_ok) begin
            mem_d[waddr] = wdata;
        end
    end

    assign rdata = r_ok ? mem_q[AW'(raddr)] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/gamma_lut_loader.sv
module gamma_lut_loader
    import gamma_lut_pkg::*;
#(
    parameter int SEG_ENTRIES = 256,
    parameter int SF_ENTRIES  = 9,
    parameter int RD_W        = $clog2(SEG_ENTRIES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      wr_addr,
    input  logic [31:0]     wr_data,
    input  logic [1:0]      rd_seg,
    input  logic [RD_W-1:0] rd_idx,
    output logic [47:0]     rd_entry,
    output logic [15:0]     max_r,
    output logic [15:0]     max_g,
    output logic [15:0]     max_b,
    output logic            ovf_sf,
    output logic            ovf_ms
);

    localparam int FINE_DEPTH = SEG_ENTRIES + 1;
    localparam int MS_DEPTH   = 2 * SEG_ENTRIES;
    localparam int MS_PW      = $clog2(MS_DEPTH + 1);
    localparam int SF_PW      = $clog2(SF_ENTRIES + 1);
    localparam int FINE_AW    = $clog2(FINE_DEPTH);
    localparam int CRS_AW     = $clog2(SEG_ENTRIES);
    localparam int SF_AW      = $clog2(SF_ENTRIES);
    localparam int NCH        = 3;

    // register decode
    logic sf_idx_wr, sf_data_wr, ms_idx_wr, ms_data_wr;
    assign sf_idx_wr  = wr_en && (wr_addr == REG_SF_INDEX);
    assign sf_data_wr = wr_en && (wr_addr == REG_SF_DATA);
    assign ms_idx_wr  = wr_en && (wr_addr == REG_MS_INDEX);
    assign ms_data_wr = wr_en && (wr_addr == REG_MS_DATA);

    // superfine stream
    logic             sf_commit;
    logic [SF_PW-1:0] sf_ptr;
    lut_entry_t       sf_entry;

    gamma_stream_ctl #(.DEPTH(SF_ENTRIES), .PTR_W(SF_PW)) u_sf_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (sf_idx_wr),
        .data_wr (sf_data_wr),
        .wdata   (wr_data),
        .commit  (sf_commit),
        .ptr     (sf_ptr),
        .entry   (sf_entry),
        .ovf     (ovf_sf)
    );

    // shared fine/coarse stream
    logic             ms_commit;
    logic [MS_PW-1:0] ms_ptr;
    lut_entry_t       ms_entry;

    gamma_stream_ctl #(.DEPTH(MS_DEPTH), .PTR_W(MS_PW)) u_ms_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (ms_idx_wr),
        .data_wr (ms_data_wr),
        .wdata   (wr_data),
        .commit  (ms_commit),
        .ptr     (ms_ptr),
        .entry   (ms_entry),
        .ovf     (ovf_ms)
    );

    // segment address mapping: fine slot = ptr + 1, coarse slot = ptr - SEG_ENTRIES
    logic                in_fine;
    logic [FINE_AW-1:0]  fine_waddr;
    logic [CRS_AW-1:0]   crs_waddr;
    logic                fine_we, crs_we;

    assign in_fine    = ms_ptr < MS_PW'(SEG_ENTRIES);
    assign fine_waddr = FINE_AW'(ms_ptr + MS_PW'(1));
    assign crs_waddr  = CRS_AW'(ms_ptr - MS_PW'(SEG_ENTRIES));
    assign fine_we    = ms_commit && in_fine;
    assign crs_we     = ms_commit && !in_fine;

    lut_entry_t sf_rdata, fine_rdata, crs_rdata;

    gamma_seg_mem #(.DEPTH(SF_ENTRIES), .AW(SF_AW), .RAW(RD_W)) u_sf_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sf_commit),
        .waddr (SF_AW'(sf_ptr)),
        .wdata (sf_entry),
        .raddr (rd_idx),
        .rdata (sf_rdata)
    );

    gamma_seg_mem #(.DEPTH(FINE_DEPTH), .AW(FINE_AW), .RAW(RD_W)) u_fine_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (fine_we),
        .waddr (fine_waddr),
        .wdata (ms_entry),
        .raddr (rd_idx),
        .rdata (fine_rdata)
    );

    gamma_seg_mem #(.DEPTH(SEG_ENTRIES), .AW(CRS_AW), .RAW(RD_W)) u_crs_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (crs_we),
        .waddr (crs_waddr),
        .wdata (ms_entry),
        .raddr (rd_idx),
        .rdata (crs_rdata)
    );

    // read select
    always_comb begin
        case (seg_sel_e'(rd_seg))
            SEG_SUPERFINE: rd_entry = sf_rdata;
            SEG_FINE:      rd_entry = fine_rdata;
            SEG_COARSE:    rd_entry = crs_rdata;
            default:       rd_entry = '0;
        endcase
    end

    // endpoint registers
    logic [CH_W-1:0] max_d [NCH];
    logic [CH_W-1:0] max_q [NCH];

    always_comb begin
        max_d = max_q;
        for (int c = 0; c < NCH; c++) begin
            if (wr_en && (wr_addr == 3'(int'(REG_MAX_R) + c))) begin
                max_d[c] = wr_data[CH_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                max_q[c] <= '0;
            end
        end else begin
            max_q <= max_d;
        end
    end

    assign max_r = max_q[0];
    assign max_g = max_q[1];
    assign max_b = max_q[2];

endmodule

// File: rtl/gamma_lut_loader_chk.sv
module gamma_lut_loader_chk
    import gamma_lut_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic [15:0] wr_low,
    input logic [15:0] max_r,
    input logic [15:0] max_g,
    input logic        ovf_sf,
    input logic        ovf_ms,
    input logic        ms_commit,
    input logic        sf_commit
);

    // R6
    sf_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_sf |=> ovf_sf);

    // R6
    ms_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_ms |=> ovf_ms);

    // R6
    ms_ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_ms && !(wr_en && wr_addr == REG_MS_DATA)) |=> !ovf_ms);

    // R2
    ms_commit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ms_commit |-> (wr_en && wr_addr == REG_MS_DATA));

    // R2
    ms_commit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ms_commit |=> !ms_commit);

    // R2
    sf_commit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sf_commit |=> !sf_commit);

    // R9
    max_r_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_MAX_R) |=> (max_r == $past(wr_low)));

    // R9
    max_g_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 3'd5) |=> $stable(max_g));

endmodule

bind gamma_lut_loader gamma_lut_loader_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_low    (wr_data[15:0]),
    .max_r     (max_r),
    .max_g     (max_g),
    .ovf_sf    (ovf_sf),
    .ovf_ms    (ovf_ms),
    .ms_commit (ms_commit),
    .sf_commit (sf_commit)
);

// File: tb/gamma_lut_loader_test.sv
module gamma_lut_loader_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_seg = '0;
    logic [8:0]  rd_idx = '0;
    logic [47:0] rd_entry;
    logic [15:0] max_r, max_g, max_b;
    logic        ovf_sf, ovf_ms;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gamma_lut_loader uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_seg   (rd_seg),
        .rd_idx   (rd_idx),
        .rd_entry (rd_entry),
        .max_r    (max_r),
        .max_g    (max_g),
        .max_b    (max_b),
        .ovf_sf   (ovf_sf),
        .ovf_ms   (ovf_ms)
    );

    typedef struct {
        int          seg;
        int          idx;
        logic [47:0] exp;
        string       req;
    } item_t;

    item_t sb[$];

    function automatic logic [47:0] val(int k, int s);
        logic [15:0] r, g, b;
        r = 16'(k * 37 + s * 1001 + 5);
        g = 16'((k * 211) ^ (s << 12) ^ 16'h3c3c);
        b = 16'(16'hffff - k * 13 - s);
        return {r, g, b};
    endfunction

    function automatic logic [31:0] w1(logic [47:0] e);
        return {2'b00, e[47:38], e[31:22], e[15:6]};
    endfunction

    function automatic logic [31:0] w2(logic [47:0] e);
        return {2'b00, e[37:32], 4'b0, e[21:16], 4'b0, e[5:0], 4'b0};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic wpair(input logic [2:0] a, input logic [47:0] e);
        wr(a, w1(e));
        wr(a, w2(e));
    endtask

    task automatic expect_at(input int seg, input int idx, input logic [47:0] e, input string req);
        item_t it;
        it.seg = seg;
        it.idx = idx;
        it.exp = e;
        it.req = req;
        sb.push_back(it);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops expected entries and compares against the read port
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                rd_seg = 2'(it.seg);
                rd_idx = 9'(it.idx);
                #1;
                n_chk++;
                if (rd_entry !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: seg %0d idx %0d actual %0h expected %0h",
                             it.req, it.seg, it.idx, rd_entry, it.exp);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(max_r == 0 && max_g == 0 && max_b == 0, "R1", {max_r, max_g}, 0);
        chk(!ovf_sf && !ovf_ms, "R1", {ovf_sf, ovf_ms}, 0);
        expect_at(0, 0, '0, "R1");
        expect_at(1, 0, '0, "R1");
        expect_at(2, 255, '0, "R1");
        // R10 empty select and out-of-range index
        expect_at(3, 5, '0, "R10");
        drain();

        // R3 superfine fill
        wr(3'd0, 32'h8000);
        for (int k = 0; k < 9; k++) begin
            wpair(3'd1, val(k, 1));
            expect_at(0, k, val(k, 1), "R3");
        end
        expect_at(0, 9, '0, "R10");
        drain();

        // R2 first word alone leaves entry, second word commits
        wr(3'd0, 32'h8000);
        wr(3'd1, w1(val(0, 2)));
        expect_at(0, 0, val(0, 1), "R2");
        drain();
        wr(3'd1, w2(val(0, 2)));
        expect_at(0, 0, val(0, 2), "R2");
        expect_at(0, 1, val(1, 1), "R2");
        drain();

        // R6 superfine overflow
        wr(3'd0, 32'h8000);
        for (int k = 0; k < 9; k++) wpair(3'd1, val(k, 3));
        chk(ovf_sf == 1'b0, "R6", ovf_sf, 0);
        wpair(3'd1, val(20, 3));
        chk(ovf_sf == 1'b1, "R6", ovf_sf, 1);
        expect_at(0, 8, val(8, 3), "R6");
        expect_at(0, 0, val(0, 3), "R6");
        drain();
        wr(3'd0, 32'h8000);
        chk(ovf_sf == 1'b1, "R6", ovf_sf, 1);

        // R4 / R5 shared stream across fine and coarse
        wr(3'd2, 32'h8000);
        for (int k = 0; k < 512; k++) begin
            wpair(3'd3, val(k, 4));
            if (k < 256) expect_at(1, k + 1, val(k, 4), "R4");
            else         expect_at(2, k - 256, val(k, 4), "R5");
        end
        expect_at(1, 0, '0, "R4");
        drain();
        chk(ovf_ms == 1'b0, "R5", ovf_ms, 0);

        // R6 shared overflow
        wpair(3'd3, val(600, 4));
        chk(ovf_ms == 1'b1, "R6", ovf_ms, 1);
        expect_at(2, 255, val(511, 4), "R6");
        expect_at(1, 1, val(0, 4), "R6");
        drain();

        // R7 index write discards pending half
        wr(3'd2, 32'h8000);
        wr(3'd3, w1(val(7, 5)));
        wr(3'd2, 32'h8000);
        wpair(3'd3, val(8, 5));
        expect_at(1, 1, val(8, 5), "R7");
        expect_at(1, 2, val(1, 4), "R7");
        drain();

        // R8 start position and no auto-increment
        wr(3'd2, 32'd10);
        wpair(3'd3, val(1, 6));
        wpair(3'd3, val(2, 6));
        expect_at(1, 11, val(2, 6), "R8");
        expect_at(1, 12, val(11, 4), "R8");
        wr(3'd0, 32'd3);
        wpair(3'd1, val(3, 7));
        wpair(3'd1, val(4, 7));
        expect_at(0, 3, val(4, 7), "R8");
        expect_at(0, 4, val(4, 3), "R8");
        wr(3'd2, 32'h8000 | 32'd300);
        wpair(3'd3, val(9, 8));
        wpair(3'd3, val(10, 8));
        expect_at(2, 44, val(9, 8), "R8");
        expect_at(2, 45, val(10, 8), "R8");
        drain();

        // R9 endpoint registers
        wr(3'd4, 32'hABCD1234);
        wr(3'd5, 32'h0000FFFF);
        wr(3'd6, 32'h5A5A0001);
        chk(max_r == 16'h1234, "R9", max_r, 16'h1234);
        chk(max_g == 16'hFFFF, "R9", max_g, 16'hFFFF);
        chk(max_b == 16'h0001, "R9", max_b, 16'h0001);
        wr(3'd7, 32'h0000_1111);
        chk(max_r == 16'h1234 && max_g == 16'hFFFF && max_b == 16'h0001, "R9",
            {max_r, max_b}, {16'h1234, 16'h0001});
        expect_at(1, 11, val(2, 6), "R9");
        drain();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule